// File: doc/BRIEF.md
# DRAM Refresh Request Generator

This block paces DRAM refresh. A programmable interval value loads a 9-bit down-counter. The counter steps on a clock-enable strobe that marks the slow output-clock edges. When the count reaches one, the counter reloads and a refresh request is raised in that same step. The request stays pending until the bus is free. A built-in fixed-priority arbiter then hands the bus to refresh for one dummy-read cycle. During that cycle the refresh address is driven: a base field from the control register above a 9-bit row counter. The row counter advances once the grant is taken.

The same arbiter serves the other bus users. Refresh has the highest priority, then ordinary CPU cycles, DMA, interrupt vector fetches and, last, the external hold handshake. Software programs the block through a one-bit-selected write port. In power-save mode the counter advances only on every PSAVE_DIV-th strobe. Powerdown freezes the counter and drops any pending request.

Top module: `dram_refresh_gen`

## Requirements
- R1: After reset, refresh_pending is 0, the row part of refresh_addr (bits 8:0) is 0, refreshing is disabled and no grant output is high.
- R2: A write with wr_sel=0 loads the interval from wr_data[8:0]. While enabled, for an interval N of 2 or more, refresh_pending rises on the Nth counted strobe after the load. For an interval of 0 or 1 it rises on every counted strobe.
- R3: The counter advances only in cycles with clk_en high. While psave is high it advances only on every PSAVE_DIV-th such cycle (default 4), counted from the last register write.
- R4: refresh_pending stays high until a refresh grant is taken. Further expiries while it is pending merge into it, so one grant clears it.
- R5: With refresh_pending high and bus_free high, gnt_refresh is high in that cycle and refresh_addr equals {base, row}. refresh_pending is low in the next cycle unless a new expiry occurs on that edge.
- R6: The row advances by one after each refresh grant and wraps from 511 to 0.
- R7: Grants are fixed priority: refresh over cpu_req over dma_req over ivec_req over hold_req. At most one grant is high, and none is high while bus_free is low.
- R8: Any write with wr_sel=0 reloads the counter at once and clears a pending request.
- R9: A write with wr_sel=1 sets enable from wr_data[15] and base from wr_data[10:0]. It reloads the counter and clears a pending request. While enable is 0, no request is raised.
- R10: While pdown is high, the counter holds its value and refresh_pending is forced low. Counting resumes from the held value after pdown falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Strobe marking counter step edges |
| psave | input | 1 | Power-save: divide counter steps |
| pdown | input | 1 | Powerdown: freeze and drop request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 interval, 1 control |
| wr_data | input | 16 | Write data |
| bus_free | input | 1 | Bus can start a new cycle |
| cpu_req | input | 1 | CPU bus cycle request |
| dma_req | input | 1 | DMA bus cycle request |
| ivec_req | input | 1 | Interrupt vector fetch request |
| hold_req | input | 1 | External hold request |
| gnt_refresh | output | 1 | Refresh dummy-read grant |
| gnt_cpu | output | 1 | CPU grant |
| gnt_dma | output | 1 | DMA grant |
| gnt_ivec | output | 1 | Interrupt vector grant |
| gnt_hold | output | 1 | Hold acknowledge |
| refresh_pending | output | 1 | Refresh request outstanding |
| refresh_addr | output | 20 | {base, row} refresh address |

## Verification
The bench targets the off-by-one at the reload. A counter that reloads at zero would stretch every period by one strobe, and intervals 0 and 1 would misbehave. It piles up several expiries while the bus is held busy and then frees it. A design that queues expiries would issue a second refresh grant where the CPU should win. It also runs more than 512 refreshes back to back to catch a row counter that fails to wrap or skips a step. Finally, it exercises gated strobes, the power-save divider, powerdown and rewrites in the middle of a count. A block that ignored any of these would raise the request early, late or not at all.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
    localparam int ROW_W  = 9;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int BASE_W = ADDR_W - ROW_W;
    localparam int NREQ   = 5;
    localparam int EN_BIT = 15;

    typedef enum logic [2:0] {
        REQ_RFSH = 3'd0,
        REQ_CPU  = 3'd1,
        REQ_DMA  = 3'd2,
        REQ_IVEC = 3'd3,
        REQ_HOLD = 3'd4
    } req_idx_e;

    typedef struct packed {
        logic              enable;
        logic [BASE_W-1:0] base;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [DATA_W-1:0] d);
        ctrl_t c;
        c.enable = d[EN_BIT];
        c.base   = d[BASE_W-1:0];
        return c;
    endfunction

    function automatic logic [ADDR_W-1:0] form_addr(input logic [BASE_W-1:0] b,
                                                    input logic [ROW_W-1:0]  r);
        return {b, r};
    endfunction
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int CNT_W     = 9,
    parameter int PSAVE_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic             psave,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expire
);
    logic [CNT_W-1:0] count_q;
    logic             tick;

    generate
        if (PSAVE_DIV > 1) begin : g_div
            localparam int DIV_W = $clog2(PSAVE_DIV);
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PSAVE_DIV - 1);
            logic [DIV_W-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst || load) begin
                    div_q <= '0;
                end else if (clk_en && run) begin
                    if (!psave || div_q == DIV_LAST) div_q <= '0;
                    else                             div_q <= div_q + 1'b1;
                end
            end
            assign tick = clk_en && run && (!psave || div_q == DIV_LAST);
        end else begin : g_nodiv
            assign tick = clk_en && run;
        end
    endgenerate

    assign expire = tick && !load && (count_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= reload_val;
        end else if (tick) begin
            if (count_q <= CNT_W'(1)) count_q <= reload_val;
            else                      count_q <= count_q - 1'b1;
        end
    end

    // R2: an expiry reloads the count from the interval source
    a_r2_reload: assert property (@(posedge clk) disable iff (rst)
        expire |=> (count_q == $past(reload_val)));
    // R3, R10: with no counted strobe and no load the count holds
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(count_q));
    // R10: no expiry while not running
    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        !run |-> !expire);
endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk) begin
        if (rst)      row <= '0;
        else if (adv) row <= row + 1'b1;
    end

    // R6: one step per grant, wrapping naturally
    a_r6_step: assert property (@(posedge clk) disable iff (rst)
        adv |=> (row == $past(row) + ROW_W'(1)));
    a_r6_still: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(row));
endmodule

// File: rtl/rfsh_bus_arbiter.sv
module rfsh_bus_arbiter #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_free,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [N:0] blocked;
    assign blocked[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_pri
            assign blocked[i+1] = blocked[i] | req[i];
            assign gnt[i]       = bus_free & req[i] & ~blocked[i];
        end
    endgenerate

    // R7: single grant, none when the bus is busy, top request always served
    a_r7_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
    a_r7_busy: assert property (@(posedge clk) disable iff (rst)
        !bus_free |-> (gnt == '0));
    a_r7_top: assert property (@(posedge clk) disable iff (rst)
        (bus_free && req[0]) |-> gnt[0]);
endmodule

// File: rtl/dram_refresh_gen.sv
module dram_refresh_gen
    import refresh_pkg::*;
#(
    parameter int PSAVE_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              psave,
    input  logic              pdown,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bus_free,
    input  logic              cpu_req,
    input  logic              dma_req,
    input  logic              ivec_req,
    input  logic              hold_req,
    output logic              gnt_refresh,
    output logic              gnt_cpu,
    output logic              gnt_dma,
    output logic              gnt_ivec,
    output logic              gnt_hold,
    output logic              refresh_pending,
    output logic [ADDR_W-1:0] refresh_addr
);
    logic [ROW_W-1:0] interval_q;
    ctrl_t            ctrl_q;
    logic             load;
    logic [ROW_W-1:0] reload_val;
    logic             expire;
    logic             clr;
    logic [ROW_W-1:0] row;
    logic [NREQ-1:0]  req;
    logic [NREQ-1:0]  gnt;

    assign load       = wr_en;
    assign reload_val = (wr_en && !wr_sel) ? wr_data[ROW_W-1:0] : interval_q;
    assign clr        = load || pdown || !ctrl_q.enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            interval_q <= '0;
            ctrl_q     <= '0;
        end else if (wr_en) begin
            if (wr_sel) ctrl_q     <= decode_ctrl(wr_data);
            else        interval_q <= wr_data[ROW_W-1:0];
        end
    end

    rfsh_interval_timer #(.CNT_W(ROW_W), .PSAVE_DIV(PSAVE_DIV)) u_timer (
        .clk(clk), .rst(rst), .clk_en(clk_en), .psave(psave),
        .run(ctrl_q.enable && !pdown), .load(load),
        .reload_val(reload_val), .expire(expire)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) refresh_pending <= 1'b0;
        else            refresh_pending <= (refresh_pending && !gnt_refresh) || expire;
    end

    assign req[REQ_RFSH] = refresh_pending;
    assign req[REQ_CPU]  = cpu_req;
    assign req[REQ_DMA]  = dma_req;
    assign req[REQ_IVEC] = ivec_req;
    assign req[REQ_HOLD] = hold_req;

    rfsh_bus_arbiter #(.N(NREQ)) u_arb (
        .clk(clk), .rst(rst), .bus_free(bus_free), .req(req), .gnt(gnt)
    );

    assign gnt_refresh = gnt[REQ_RFSH];
    assign gnt_cpu     = gnt[REQ_CPU];
    assign gnt_dma     = gnt[REQ_DMA];
    assign gnt_ivec    = gnt[REQ_IVEC];
    assign gnt_hold    = gnt[REQ_HOLD];

    rfsh_row_counter #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst(rst), .adv(gnt_refresh), .row(row)
    );

    assign refresh_addr = form_addr(ctrl_q.base, row);

    // R4: a pending request survives until granted or cleared
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        (refresh_pending && !gnt_refresh && !clr) |=> refresh_pending);
    // R8, R9: a register write leaves no request pending
    a_r8_wrclear: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !refresh_pending);
    // R10: powerdown drops the request
    a_r10_pdown: assert property (@(posedge clk) disable iff (rst)
        pdown |=> !refresh_pending);
    // R5: grant only with a pending request
    a_r5_grant: assert property (@(posedge clk) disable iff (rst)
        gnt_refresh |-> refresh_pending);
endmodule

// File: tb/dram_refresh_gen_test.sv
module dram_refresh_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam int IVS [NV] = '{2, 3, 5, 9, 1, 0, 17, 3};
    localparam bit PSV [NV] = '{0, 0, 0, 0, 0, 0, 0, 1};
    localparam int EXP [NV] = '{2, 3, 5, 9, 1, 1, 17, 12};
    localparam logic [10:0] BASE = 11'h5A3;

    logic clk = 0, rst = 1, clk_en = 1, psave = 0, pdown = 0;
    logic wr_en = 0, wr_sel = 0;
    logic [15:0] wr_data = '0;
    logic bus_free = 0, cpu_req = 0, dma_req = 0, ivec_req = 0, hold_req = 0;
    logic gnt_refresh, gnt_cpu, gnt_dma, gnt_ivec, gnt_hold, refresh_pending;
    logic [19:0] refresh_addr;
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_refresh_gen uut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .psave(psave), .pdown(pdown),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .bus_free(bus_free),
        .cpu_req(cpu_req), .dma_req(dma_req), .ivec_req(ivec_req), .hold_req(hold_req),
        .gnt_refresh(gnt_refresh), .gnt_cpu(gnt_cpu), .gnt_dma(gnt_dma),
        .gnt_ivec(gnt_ivec), .gnt_hold(gnt_hold),
        .refresh_pending(refresh_pending), .refresh_addr(refresh_addr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 0;
    endtask

    function automatic int gvec();
        return {gnt_hold, gnt_ivec, gnt_dma, gnt_cpu, gnt_refresh};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n, g, r0, bad;
        repeat (3) step();
        rst = 0;
        step();
        // R1 reset state
        check(refresh_pending == 0, "R1 pending", refresh_pending, 0);
        check(refresh_addr[8:0] == 0, "R1 row", refresh_addr[8:0], 0);
        bus_free = 1;
        check(gvec() == 0, "R1 grants", gvec(), 0);
        repeat (20) step();
        check(refresh_pending == 0, "R1 disabled", refresh_pending, 0);
        bus_free = 0;

        wr(1, 16'h8000 | 16'(BASE));
        // R2 / R3 table of intervals
        for (int i = 0; i < NV; i++) begin
            psave = PSV[i];
            wr(0, 16'(IVS[i]));
            n = 0;
            while (!refresh_pending && n < 200) begin step(); n++; end
            check(n == EXP[i], PSV[i] ? "R3 psave period" : "R2 period", n, EXP[i]);
        end
        psave = 0;

        // R3 gated strobe
        wr(0, 16'd2);
        clk_en = 0;
        repeat (20) step();
        check(refresh_pending == 0, "R3 no clk_en", refresh_pending, 0);
        clk_en = 1;
        step(); step();
        check(refresh_pending == 1, "R3 resume", refresh_pending, 1);

        // R8 interval write clears pending and restarts
        wr(0, 16'd5);
        check(refresh_pending == 0, "R8 clear", refresh_pending, 0);
        repeat (4) step();
        check(refresh_pending == 0, "R8 restart early", refresh_pending, 0);
        step();
        check(refresh_pending == 1, "R8 restart", refresh_pending, 1);

        // R4 merge, R5 grant address, R7 refresh first
        wr(0, 16'd3);
        r0 = refresh_addr[8:0];
        repeat (7) step();
        check(refresh_pending == 1, "R4 sticky", refresh_pending, 1);
        bus_free = 1; cpu_req = 1; dma_req = 1; hold_req = 1;
        #1;
        check(gvec() == 1, "R7 refresh wins", gvec(), 1);
        check(refresh_addr == {BASE, 9'(r0)}, "R5 addr", refresh_addr, {BASE, 9'(r0)});
        step();
        check(refresh_pending == 0, "R4 merged", refresh_pending, 0);
        check(gvec() == 2, "R5 cpu next", gvec(), 2);
        check(refresh_addr[8:0] == 9'(r0 + 1), "R6 step", refresh_addr[8:0], r0 + 1);
        bus_free = 0;

        // R7 lower priorities
        wr(1, 16'(BASE));
        bus_free = 1; cpu_req = 0;
        #1;
        check(gvec() == 4, "R7 dma", gvec(), 4);
        dma_req = 0; ivec_req = 1;
        #1;
        check(gvec() == 8, "R7 ivec", gvec(), 8);
        ivec_req = 0;
        #1;
        check(gvec() == 16, "R7 hold", gvec(), 16);
        bus_free = 0;
        #1;
        check(gvec() == 0, "R7 busy", gvec(), 0);
        hold_req = 0;

        // R9 disabled: no request
        wr(0, 16'd2);
        repeat (30) step();
        check(refresh_pending == 0, "R9 disabled", refresh_pending, 0);
        wr(1, 16'h8000 | 16'(BASE));
        step(); step();
        check(refresh_pending == 1, "R9 enabled", refresh_pending, 1);
        wr(1, 16'h8000 | 16'(BASE));
        check(refresh_pending == 0, "R9 ctrl write clears", refresh_pending, 0);

        // R10 powerdown
        step(); step();
        check(refresh_pending == 1, "R10 pre", refresh_pending, 1);
        pdown = 1;
        step();
        check(refresh_pending == 0, "R10 drop", refresh_pending, 0);
        repeat (6) step();
        check(refresh_pending == 0, "R10 frozen", refresh_pending, 0);
        pdown = 0;
        step();
        check(refresh_pending == 0, "R10 resume early", refresh_pending, 0);
        step();
        check(refresh_pending == 1, "R10 resume", refresh_pending, 1);

        // R6 row wrap over many refreshes
        wr(0, 16'd1);
        r0 = refresh_addr[8:0];
        bus_free = 1;
        g = 0; bad = 0;
        for (int k = 0; k < 560; k++) begin
            #1;
            if (gnt_refresh) begin
                if (refresh_addr[8:0] != 9'(r0 + g)) bad++;
                g++;
            end
            step();
        end
        check(bad == 0 && g >= 512, "R6 wrap", bad, 0);
        check(refresh_addr[8:0] == 9'(r0 + g), "R6 final row", refresh_addr[8:0], (r0 + g) % 512);
        bus_free = 0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule